// File: doc/BRIEF.md
# Phase-Steppable Pulse-Per-Second Divider

This block turns a fast reference clock into a set of once-per-period timing pulses. Each output channel has its own modulo counter. The counter runs from 0 to `DIV_RATIO-1` and wraps, so with the default ratio a 10 MHz reference gives one pulse per second. A 200 MHz reference needs a ratio of 200,000,000. All channels share the same clock and the same external sync strobe. Each channel keeps its own offset, pulse width, preset value and phase-step commands.

A sync strobe restarts every channel. Each channel then places its next pulse a programmed number of reference periods after the sync. That offset is signed, so a channel can lead the sync by wrapping its start point around the period. At run time a channel can be preset to any count. It can also be slewed one reference period earlier or later, and the pulse train is not broken while this happens. Each pulse is made by a width counter. The last stage is a single flop clocked on the falling clock edge, so output edges sit half a period away from the logic that drives them.

Top module: `pps_divider`

## Requirements
- R1: With no commands applied, a channel's output pulses rise exactly `DIV_RATIO` clock periods apart, and the internal count never leaves 0..`DIV_RATIO-1`.
- R2: Each pulse stays high for the programmed width, clamped to the range 1..`DIV_RATIO-2`. A width of 0 gives 1, and any value above `DIV_RATIO-2` gives `DIV_RATIO-2`.
- R3: Let a sync strobe be sampled at rising edge 1, and let a channel's offset D satisfy 0 <= D < `DIV_RATIO`. That channel's output then first reads high after rising edge D+2. The offset is a two's-complement field of `CNT_W+1` bits per channel, with channel k at bits [k*(CNT_W+1) +: CNT_W+1].
- R4: A negative offset -`DIV_RATIO` < D < 0 wraps modulo the ratio. The first pulse after sync then reads high after rising edge `DIV_RATIO`+D+2, and no pulse appears before that.
- R5: An advance request makes one output period `DIV_RATIO-1` clocks long. A retard request makes one period `DIV_RATIO+1` clocks long. Later periods return to `DIV_RATIO`. A request is held pending and takes effect when the count reaches `DIV_RATIO/2`. Requests that arrive while one is pending, or during sync, are ignored. If advance and retard are raised together, neither takes effect.
- R6: Each accepted adjustment produces exactly one single-cycle acknowledge strobe on that channel. Channels with no request never acknowledge.
- R7: Outputs change only at falling clock edges. The value seen just after a rising edge equals the value seen after the preceding falling edge.
- R8: A sync strobe forces every output low from the clock after sync, which cuts short any pulse in progress.
- R9: A preset strobe loads the count with value V (V < `DIV_RATIO`) at rising edge 1. The next pulse then reads high after rising edge `DIV_RATIO`-V+2, and the following pulse comes one full period later.
- R10: Channels are independent. An offset, preset or step on one channel does not move the pulses of another channel.
- R11: While reset is asserted, every output pulse and acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Realign strobe, shared by all channels |
| load_i | input | NUM_CH | Per-channel preset strobe |
| load_val_i | input | NUM_CH*CNT_W | Per-channel preset count |
| offset_i | input | NUM_CH*(CNT_W+1) | Per-channel signed delay after sync, in clocks |
| width_i | input | NUM_CH*CNT_W | Per-channel pulse width, in clocks |
| advance_i | input | NUM_CH | Per-channel request to step one clock earlier |
| retard_i | input | NUM_CH | Per-channel request to step one clock later |
| pps_o | output | NUM_CH | Retimed pulse outputs |
| step_ack_o | output | NUM_CH | One-cycle acknowledge of an applied step |

## Verification
The hardest case to reach is a step request that is already pending when a second request arrives. It only occurs between the capture cycle and the mid-period apply point. The bench places the first retard one clock after a measured pulse edge, then repeats the request on the very next clock, while the first is still waiting. It checks that the period grows by one clock only and that a single acknowledge appears. The bench also raises both step inputs together on the second channel within the same run, and checks that this changes nothing there. For truncation, sync is reissued while a wide pulse is known to be high.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Pending phase adjustment held by a channel until mid-period
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_EARLY = 2'd1,
    ADJ_LATE  = 2'd2
  } adj_e;
endpackage

// File: rtl/pps_phase_counter.sv
module pps_phase_counter
  import pps_pkg::*;
#(
  parameter int DIV   = 20,
  parameter int CNT_W = 5,
  parameter int OFS_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_i,
  input  logic                    load_i,
  input  logic [CNT_W-1:0]        load_val_i,
  input  logic signed [OFS_W-1:0] offset_i,
  input  logic                    adv_i,
  input  logic                    ret_i,
  output logic                    fire_o,
  output logic                    ack_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(DIV / 2);

  // Start count after sync: a delay of D clocks means starting D short of wrap
  function automatic logic [CNT_W-1:0] start_of(input logic signed [OFS_W-1:0] ofs);
    int o;
    o = int'(ofs);
    return (o <= 0) ? CNT_W'(-o) : CNT_W'(DIV - o);
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  adj_e             pend_q, pend_d;
  logic             ack_q;

  // Named internal events
  logic step_req, step_capture, step_apply;
  assign step_req     = adv_i ^ ret_i;
  assign step_capture = !sync_i && step_req && (pend_q == ADJ_NONE);
  assign step_apply   = (pend_q != ADJ_NONE) && (cnt_q == MID) && !sync_i && !load_i;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    if (sync_i)          cnt_d = start_of(offset_i);
    else if (load_i)     cnt_d = load_val_i;
    else if (step_apply) cnt_d = (pend_q == ADJ_EARLY) ? cnt_q + CNT_W'(2) : cnt_q;

    pend_d = pend_q;
    if (sync_i || step_apply) pend_d = ADJ_NONE;
    else if (step_capture)    pend_d = adv_i ? ADJ_EARLY : ADJ_LATE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= ADJ_NONE;
      ack_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      ack_q  <= step_apply;
    end
  end

  assign fire_o = (cnt_q == '0) && !sync_i;
  assign ack_o  = ack_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_sync_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && offset_i == '0) |=> (cnt_q == '0));
  p_late_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_apply && pend_q == ADJ_LATE) |=> $stable(cnt_q));
  p_early_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_apply && pend_q == ADJ_EARLY) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(2))));
  p_ack_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
endmodule

// File: rtl/pps_pulse_shaper.sv
module pps_pulse_shaper #(
  parameter int DIV   = 20,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             raw_o
);
  localparam logic [CNT_W-1:0] WMAX = CNT_W'(DIV - 2);

  // Keep the pulse at least one clock and leave at least two low clocks
  function automatic logic [CNT_W-1:0] clamp_width(input logic [CNT_W-1:0] w);
    if (w == '0)  return CNT_W'(1);
    if (w > WMAX) return WMAX;
    return w;
  endfunction

  logic [CNT_W-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            wcnt_q <= '0;
    else if (sync_i)        wcnt_q <= '0;
    else if (fire_i)        wcnt_q <= clamp_width(width_i);
    else if (wcnt_q != '0)  wcnt_q <= wcnt_q - CNT_W'(1);
  end

  assign raw_o = (wcnt_q != '0);

  p_trunc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !raw_o);
  p_width_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= WMAX);
endmodule

// File: rtl/pps_retime.sv
module pps_retime (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/pps_divider.sv
module pps_divider #(
  parameter int DIV_RATIO = 10_000_000,
  parameter int NUM_CH    = 2,
  localparam int CNT_W    = $clog2(DIV_RATIO),
  localparam int OFS_W    = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_i,
  input  logic [NUM_CH-1:0]       load_i,
  input  logic [NUM_CH*CNT_W-1:0] load_val_i,
  input  logic [NUM_CH*OFS_W-1:0] offset_i,
  input  logic [NUM_CH*CNT_W-1:0] width_i,
  input  logic [NUM_CH-1:0]       advance_i,
  input  logic [NUM_CH-1:0]       retard_i,
  output logic [NUM_CH-1:0]       pps_o,
  output logic [NUM_CH-1:0]       step_ack_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic fire, raw;

    pps_phase_counter #(.DIV(DIV_RATIO), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync_i),
      .load_i     (load_i[ch]),
      .load_val_i (load_val_i[ch*CNT_W +: CNT_W]),
      .offset_i   (offset_i[ch*OFS_W +: OFS_W]),
      .adv_i      (advance_i[ch]),
      .ret_i      (retard_i[ch]),
      .fire_o     (fire),
      .ack_o      (step_ack_o[ch])
    );

    pps_pulse_shaper #(.DIV(DIV_RATIO), .CNT_W(CNT_W)) u_shape (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync_i),
      .fire_i  (fire),
      .width_i (width_i[ch*CNT_W +: CNT_W]),
      .raw_o   (raw)
    );

    pps_retime u_rt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw),
      .q_o    (pps_o[ch])
    );

    // At a rising edge the retimed output already carries the shaper value
    p_retime_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pps_o[ch] == raw);
  end
endmodule

// File: tb/pps_divider_bench.sv
module pps_divider_bench;
  localparam int DIV   = 20;
  localparam int NCH   = 2;
  localparam int CNT_W = $clog2(DIV);
  localparam int OFS_W = CNT_W + 1;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   sync = 1'b0;
  logic [NCH-1:0]         load = '0;
  logic [NCH*CNT_W-1:0]   load_val = '0;
  logic [NCH*OFS_W-1:0]   offset = '0;
  logic [NCH*CNT_W-1:0]   width = '0;
  logic [NCH-1:0]         adv = '0;
  logic [NCH-1:0]         ret = '0;
  logic [NCH-1:0]         pps;
  logic [NCH-1:0]         ack;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int rise [NCH][2];
  int wid  [NCH];
  int acks [NCH];
  int first[NCH];

  always #10 clk = ~clk;

  pps_divider #(.DIV_RATIO(DIV), .NUM_CH(NCH)) u_pps_divider (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .load_i(load),
    .load_val_i(load_val), .offset_i(offset), .width_i(width),
    .advance_i(adv), .retard_i(ret), .pps_o(pps), .step_ack_o(ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sample/drive point: just after a falling edge
  task automatic cycle();
    @(negedge clk);
    #2;
  endtask

  task automatic set_ch(input int ch, input int ofs, input int w);
    offset[ch*OFS_W +: OFS_W] = OFS_W'(ofs);
    width[ch*CNT_W +: CNT_W]  = CNT_W'(w);
  endtask

  // Runs len cycles, clears strobes after the first edge, records pulse timing
  task automatic observe(input int len);
    logic [NCH-1:0] prev;
    int nr[NCH];
    int bad;
    bad = 0;
    prev = pps;
    for (int c = 0; c < NCH; c++) begin
      nr[c] = 0; wid[c] = 0; acks[c] = 0; first[c] = -1;
      rise[c][0] = -1; rise[c][1] = -1;
    end
    for (int i = 1; i <= len; i++) begin
      @(posedge clk);
      #2;
      if (pps !== prev) bad++;  // R7: no change at the rising edge
      cycle();
      if (i == 1) begin
        sync = 1'b0; load = '0; adv = '0; ret = '0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (i == 1) first[c] = int'(pps[c]);
        if (pps[c] && !prev[c] && nr[c] < 2) begin
          rise[c][nr[c]] = i;
          nr[c]++;
        end
        if (pps[c] && nr[c] == 1) wid[c]++;
        if (ack[c]) acks[c]++;
      end
      prev = pps;
    end
    chk("R7 retime edge", bad, 0);
  endtask

  task automatic do_sync();
    sync = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cycle();
    chk("R11 pps in reset", int'(pps), 0);
    chk("R11 ack in reset", int'(ack), 0);
    rst_n = 1'b1;
    cycle();
  endtask

  task automatic t_sync_offset();
    set_ch(0, 0, 3); set_ch(1, 5, 3);
    do_sync();
    observe(50);
    chk("R3 ch0 first rise", rise[0][0], 2);
    chk("R1 ch0 period", rise[0][1] - rise[0][0], DIV);
    chk("R2 ch0 width", wid[0], 3);
    chk("R10 ch1 first rise", rise[1][0], 7);
    chk("R1 ch1 period", rise[1][1] - rise[1][0], DIV);
  endtask

  task automatic t_neg_offset();
    set_ch(0, -2, 3); set_ch(1, DIV - 1, 3);
    do_sync();
    observe(30);
    chk("R4 ch0 wrapped rise", rise[0][0], DIV - 2 + 2);
    chk("R3 ch1 max offset", rise[1][0], DIV - 1 + 2);
  endtask

  task automatic t_width_clamp();
    set_ch(0, 0, 0); set_ch(1, 0, 31);
    do_sync();
    observe(30);
    chk("R2 width 0 -> 1", wid[0], 1);
    chk("R2 width clamp", wid[1], DIV - 2);
    chk("R2 clamped period", rise[1][1] - rise[1][0], DIV);
  endtask

  task automatic t_advance();
    set_ch(0, 0, 3); set_ch(1, 0, 3);
    do_sync();
    observe(5);
    adv[0] = 1'b1;
    adv[1] = 1'b1; ret[1] = 1'b1;  // both at once on ch1: ignored
    observe(45);
    chk("R5 advanced rise", rise[0][0], 16);
    chk("R5 period restored", rise[0][1] - rise[0][0], DIV);
    chk("R6 advance ack", acks[0], 1);
    chk("R5 both-request ignored", rise[1][0], 17);
    chk("R6 no ack ch1", acks[1], 0);
  endtask

  task automatic t_retard();
    set_ch(0, 0, 3); set_ch(1, 0, 3);
    do_sync();
    observe(5);
    ret[0] = 1'b1;
    observe(45);
    chk("R5 retarded rise", rise[0][0], 18);
    chk("R6 retard ack", acks[0], 1);
    chk("R10 ch1 unmoved", rise[1][0], 17);
  endtask

  task automatic t_pending_ignore();
    set_ch(0, 0, 3); set_ch(1, 0, 3);
    do_sync();
    observe(5);
    ret[0] = 1'b1;
    cycle();
    ret[0] = 1'b1;  // arrives while the first is pending
    observe(44);
    chk("R5 second request ignored", rise[0][0], 17);
    chk("R5 period after step", rise[0][1] - rise[0][0], DIV);
    chk("R6 single ack", acks[0], 1);
    chk("R10 ch1 unmoved", rise[1][0], 16);
  endtask

  task automatic t_load();
    set_ch(0, 0, 3); set_ch(1, 0, 3);
    do_sync();
    observe(5);
    load[0] = 1'b1;
    load_val[0 +: CNT_W] = CNT_W'(17);
    observe(40);
    chk("R9 preset rise", rise[0][0], DIV - 17 + 2);
    chk("R9 preset period", rise[0][1] - rise[0][0], DIV);
    chk("R10 ch1 unmoved", rise[1][0], 17);
  endtask

  task automatic t_truncate();
    set_ch(0, 0, 8); set_ch(1, 0, 8);
    do_sync();
    observe(4);
    chk("R2 pulse high before sync", int'(pps[0]), 1);
    do_sync();
    observe(30);
    chk("R8 truncated after sync", first[0], 0);
    chk("R8 ch1 truncated", first[1], 0);
    chk("R3 rise after truncation", rise[0][0], 2);
    chk("R2 full width after", wid[0], 8);
  endtask

  initial begin
    t_reset();
    t_sync_offset();
    t_neg_offset();
    t_width_clamp();
    t_advance();
    t_retard();
    t_pending_ignore();
    t_load();
    t_truncate();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule